// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Recognition

This block receives asynchronous serial frames on one input line. The line is sampled on every pulse of an external baud tick that runs at sixteen times the bit rate. A falling edge starts a frame. The start bit and every later bit are decided by a majority vote over three samples near the middle of the bit. The receiver collects eight or nine data bits, least significant first, as a mode input selects. It then checks the stop bit and loads the received word and its status into a holding register.

A frame whose data field is entirely zero and whose stop bit is also zero is a break. A break sets the framing-error flag and a dedicated break flag, delivers a zero data word and marks the register full. The noise, parity and overrun flags are still evaluated for a break frame. After any frame with a low stop bit, the receiver waits for the line to go high again before it accepts a new start. The optional parity check uses the top data bit as the parity bit, so a parity policy sits outside this block. A one-cycle read strobe empties the holding register and clears the status.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset, every status flag and the receive-active flag read 0 and the data register reads 0.
- R2: In 8-bit mode (nine_bit_i = 0) a frame with a high stop bit loads its data bits, least significant first, into rx_data_o[7:0]. Bit 8 reads 0, rdrf_o goes to 1 and fe_o stays 0.
- R3: Each bit spans 16 baud ticks. Its value is the majority of samples 7, 8 and 9, counted from the detecting tick as sample 1. If those three samples disagree in any bit of the frame, nf_o is set, and the data still takes the majority value.
- R4: In 9-bit mode (nine_bit_i = 1) nine data bits are received into rx_data_o[8:0], least significant first.
- R5: A start bit whose majority vote is high counts as a false start. It does not fill the register, and the receiver returns to idle.
- R6: A low stop bit after a data field that is not all zero sets fe_o and rdrf_o, loads the received data and leaves brk_o at 0.
- R7: A start bit followed by all-zero data and a low stop bit is a break. It sets fe_o, brk_o and rdrf_o and leaves rx_data_o at 0.
- R8: In 9-bit mode a break needs all nine data bits at zero. If bit 8 is 1 and the stop bit is low, the result is a framing error with brk_o at 0.
- R9: After a low stop bit the receiver accepts no new start until the line has been seen high on a tick. A line held low does not produce further frames.
- R10: A frame that completes while rdrf_o is 1 sets or_o. That frame is discarded, and rx_data_o and the other flags keep their values.
- R11: A one-cycle pulse on rd_i clears rdrf_o, fe_o, nf_o, pe_o, or_o and brk_o, and leaves rx_data_o unchanged.
- R12: With par_en_i = 1 the top data bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is a parity bit. pe_o is set when the exclusive-or of all data bits differs from par_odd_i, where 0 selects even and 1 selects odd. A break under odd parity therefore also sets pe_o.
- R13: raf_o is 1 while a frame is being received and 0 when the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial input line, idle high |
| baud_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| nine_bit_i | input | 1 | 1 = nine data bits, 0 = eight |
| par_en_i | input | 1 | Treat top data bit as parity |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| rd_i | input | 1 | Read strobe: empties register, clears flags |
| rx_data_o | output | DATA_W | Receive data register |
| rdrf_o | output | 1 | Receive data register full |
| fe_o | output | 1 | Framing error |
| or_o | output | 1 | Overrun |
| nf_o | output | 1 | Noise detected |
| pe_o | output | 1 | Parity error |
| brk_o | output | 1 | Break frame received |
| raf_o | output | 1 | Receiver active |

## Verification
A frame's result is due three clock cycles after the tick that takes sample 9 of the stop bit. That tick captures the sample, the vote result is registered, the frame engine registers the result, and the status register loads it. The bench sends every bit as sixteen tick-aligned slots, changed on falling clock edges. It reads the flags only once the whole stop bit has been sent, which is seven sample periods after they became valid. For the negative cases (false start, held-low line after a break, overrun), the bench samples only after a window several bit times long in which a wrong frame would already have shown up. The read strobe is checked on the clock cycle after the pulse.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HI
  } rx_state_e;

  typedef struct packed {
    logic fe;
    logic nf;
    logic pe;
    logic brk;
  } rx_err_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain[g] <= rst ? 1'b1 : din;
      end else begin : g_rest
        always_ff @(posedge clk) chain[g] <= rst ? 1'b1 : chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line,
  input  logic align,
  output logic bit_vld,
  output logic bit_val,
  output logic bit_noisy
);
  localparam int W    = $clog2(OSR);
  localparam int S_LO = OSR / 2 - 1;
  localparam int S_MD = OSR / 2;
  localparam int S_HI = OSR / 2 + 1;

  logic [W-1:0] idx;
  logic [W-1:0] nxt;
  logic         s_lo, s_md;

  assign nxt = (idx == W'(OSR - 1)) ? '0 : idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      s_lo      <= 1'b1;
      s_md      <= 1'b1;
      bit_vld   <= 1'b0;
      bit_val   <= 1'b1;
      bit_noisy <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      if (align) begin
        idx <= W'(1);
      end else if (tick) begin
        idx <= nxt;
        if (nxt == W'(S_LO)) s_lo <= line;
        if (nxt == W'(S_MD)) s_md <= line;
        if (nxt == W'(S_HI)) begin
          bit_vld   <= 1'b1;
          bit_val   <= (s_lo & s_md) | (s_lo & line) | (s_md & line);
          bit_noisy <= !((s_lo == s_md) && (s_md == line));
        end
      end
    end
  end

  // R3: one decision per bit, never two in a row
  p_vote_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> !bit_vld);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              nine_bit,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              bit_noisy,
  output logic              align,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output rx_err_t           err
);
  localparam int CW = $clog2(DATA_W);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     last_idx;
  logic [DATA_W-1:0] shf;
  logic              noisy;
  logic              zero_field;

  assign align      = (st == RX_IDLE) && tick && !line;
  assign active     = (st != RX_IDLE);
  assign last_idx   = nine_bit ? CW'(DATA_W - 1) : CW'(DATA_W - 2);
  assign zero_field = (shf == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      shf   <= '0;
      noisy <= 1'b0;
      done  <= 1'b0;
      data  <= '0;
      err   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        RX_IDLE: if (align) begin
          st    <= RX_START;
          cnt   <= '0;
          shf   <= '0;
          noisy <= 1'b0;
        end
        RX_START: if (bit_vld) begin
          if (bit_val) st <= RX_IDLE;
          else begin
            st    <= RX_DATA;
            noisy <= bit_noisy;
          end
        end
        RX_DATA: if (bit_vld) begin
          shf[cnt] <= bit_val;
          noisy    <= noisy | bit_noisy;
          cnt      <= cnt + 1'b1;
          if (cnt == last_idx) st <= RX_STOP;
        end
        RX_STOP: if (bit_vld) begin
          done    <= 1'b1;
          data    <= (!bit_val && zero_field) ? '0 : shf;
          err.fe  <= !bit_val;
          err.brk <= !bit_val && zero_field;
          err.nf  <= noisy | bit_noisy;
          err.pe  <= par_en && ((^shf) != par_odd);
          st      <= bit_val ? RX_IDLE : RX_WAIT_HI;
        end
        RX_WAIT_HI: if (tick && line) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R9: a low line keeps the receiver parked after a low stop bit
  p_park_low_r9: assert property (@(posedge clk) disable iff (rst)
    (st == RX_WAIT_HI && !line) |=> (st == RX_WAIT_HI));
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_i,
  input  logic              baud_tick_i,
  input  logic              nine_bit_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rdrf_o,
  output logic              fe_o,
  output logic              or_o,
  output logic              nf_o,
  output logic              pe_o,
  output logic              brk_o,
  output logic              raf_o
);
  logic              line, align, bit_vld, bit_val, bit_noisy;
  logic              active, frame_done, full_eff;
  logic [DATA_W-1:0] frame_data;
  rx_err_t           frame_err;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd_i), .dout(line));

  uart_rx_vote #(.OSR(OSR)) u_vote (
    .clk(clk), .rst(rst), .tick(baud_tick_i), .line(line), .align(align),
    .bit_vld(bit_vld), .bit_val(bit_val), .bit_noisy(bit_noisy));

  uart_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .tick(baud_tick_i), .line(line),
    .nine_bit(nine_bit_i), .par_en(par_en_i), .par_odd(par_odd_i),
    .bit_vld(bit_vld), .bit_val(bit_val), .bit_noisy(bit_noisy),
    .align(align), .active(active), .done(frame_done),
    .data(frame_data), .err(frame_err));

  assign full_eff = rdrf_o && !rd_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data_o <= '0;
      rdrf_o    <= 1'b0;
      fe_o      <= 1'b0;
      or_o      <= 1'b0;
      nf_o      <= 1'b0;
      pe_o      <= 1'b0;
      brk_o     <= 1'b0;
      raf_o     <= 1'b0;
    end else begin
      raf_o <= active;
      if (rd_i) begin
        rdrf_o <= 1'b0;
        fe_o   <= 1'b0;
        or_o   <= 1'b0;
        nf_o   <= 1'b0;
        pe_o   <= 1'b0;
        brk_o  <= 1'b0;
      end
      if (frame_done) begin
        if (full_eff) begin
          or_o <= 1'b1;
        end else begin
          rx_data_o <= frame_data;
          rdrf_o    <= 1'b1;
          fe_o      <= frame_err.fe;
          nf_o      <= frame_err.nf;
          pe_o      <= frame_err.pe;
          brk_o     <= frame_err.brk;
        end
      end
    end
  end

  // R7: a break always comes with a framing error and a zero word
  p_break_zero_r7: assert property (@(posedge clk) disable iff (rst)
    brk_o |-> (fe_o && rx_data_o == '0));

  // R10: overrun keeps the held word and the full flag
  p_overrun_hold_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(or_o) |-> ($stable(rx_data_o) && rdrf_o));

  // R11: a read with no frame landing empties the register
  p_read_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !frame_done) |=> (!rdrf_o && !fe_o && !or_o && !brk_o));

  // R2: a completed frame into an empty register fills it
  p_fill_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !rdrf_o) |=> rdrf_o);
endmodule

// File: tb/uart_rx_brk_bench.sv
`timescale 1ns/1ps
module uart_rx_brk_bench;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       nine = 1'b0, pen = 1'b0, podd = 1'b0, rd = 1'b0;
  logic [1:0] tcnt = '0;
  logic       tick;
  logic [8:0] data;
  logic       rdrf, fe, ovr, nf, pe, brk, raf;
  int         checks = 0, errors = 0;

  always #10 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 1'b1;
  assign tick = (tcnt == 2'(TDIV - 1));

  uart_rx_brk u_uart_rx_brk (
    .clk(clk), .rst(rst), .rxd_i(rxd), .baud_tick_i(tick),
    .nine_bit_i(nine), .par_en_i(pen), .par_odd_i(podd), .rd_i(rd),
    .rx_data_o(data), .rdrf_o(rdrf), .fe_o(fe), .or_o(ovr), .nf_o(nf),
    .pe_o(pe), .brk_o(brk), .raf_o(raf));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slots(logic v, int n);
    rxd = v;
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic send_bit(logic v, int gslot);
    for (int s = 1; s <= 16; s++) begin
      rxd = (s == gslot) ? !v : v;
      repeat (TDIV) @(negedge clk);
    end
  endtask

  task automatic send_frame(logic [8:0] d, int n, logic stop, int gbit, int gslot);
    send_bit(1'b0, 0);
    for (int i = 0; i < n; i++) send_bit(d[i], (i == gbit) ? gslot : 0);
    send_bit(stop, 0);
  endtask

  task automatic read_clear();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdrf", rdrf, 0); check("R1 fe", fe, 0); check("R1 or", ovr, 0);
    check("R1 nf", nf, 0); check("R1 pe", pe, 0); check("R1 brk", brk, 0);
    check("R1 raf", raf, 0); check("R1 data", data, 0);
  endtask

  task automatic t_basic8();
    nine = 0;
    send_frame(9'h0A5, 8, 1'b1, -1, 0); slots(1'b1, 4);
    check("R2 data", data, 9'h0A5); check("R2 rdrf", rdrf, 1);
    check("R2 fe", fe, 0); check("R2 nf", nf, 0);
    read_clear();
    send_frame(9'h13C, 8, 1'b1, -1, 0); slots(1'b1, 4);
    check("R2 data bit8 zero", data, 9'h03C);
    read_clear();
  endtask

  task automatic t_noise();
    send_frame(9'h05A, 8, 1'b1, 3, 8); slots(1'b1, 4);
    check("R3 majority data", data, 9'h05A); check("R3 nf", nf, 1);
    read_clear();
  endtask

  task automatic t_nine();
    nine = 1;
    send_frame(9'h1C3, 9, 1'b1, -1, 0); slots(1'b1, 4);
    check("R4 data", data, 9'h1C3); check("R4 rdrf", rdrf, 1);
    read_clear();
    nine = 0;
  endtask

  task automatic t_false_start();
    slots(1'b0, 5); slots(1'b1, 40);
    check("R5 rdrf", rdrf, 0); check("R5 raf", raf, 0);
  endtask

  task automatic t_frame_err();
    send_frame(9'h081, 8, 1'b0, -1, 0); slots(1'b1, 4);
    check("R6 fe", fe, 1); check("R6 brk", brk, 0);
    check("R6 data", data, 9'h081); check("R6 rdrf", rdrf, 1);
    read_clear();
  endtask

  task automatic t_break();
    send_frame(9'h000, 8, 1'b0, -1, 0); slots(1'b0, 4); slots(1'b1, 4);
    check("R7 fe", fe, 1); check("R7 brk", brk, 1);
    check("R7 rdrf", rdrf, 1); check("R7 data", data, 0);
    read_clear();
    check("R11 data kept", data, 0); check("R11 flags", {rdrf, fe, brk}, 0);
  endtask

  task automatic t_break9();
    nine = 1;
    send_frame(9'h100, 9, 1'b0, -1, 0); slots(1'b1, 4);
    check("R8 fe", fe, 1); check("R8 brk", brk, 0); check("R8 data", data, 9'h100);
    read_clear();
    send_frame(9'h000, 9, 1'b0, -1, 0); slots(1'b1, 4);
    check("R8 full 9-bit break", brk, 1);
    read_clear();
    nine = 0;
  endtask

  task automatic t_wait_high();
    send_frame(9'h000, 8, 1'b0, -1, 0);
    read_clear();
    slots(1'b0, 48);
    check("R9 no frame while low", rdrf, 0);
    slots(1'b1, 16);
    send_frame(9'h033, 8, 1'b1, -1, 0); slots(1'b1, 4);
    check("R9 next frame", data, 9'h033); check("R9 no fe", fe, 0);
    read_clear();
  endtask

  task automatic t_overrun();
    send_frame(9'h011, 8, 1'b1, -1, 0); slots(1'b1, 4);
    send_frame(9'h0EE, 8, 1'b1, -1, 0); slots(1'b1, 4);
    check("R10 or", ovr, 1); check("R10 data kept", data, 9'h011);
    check("R10 rdrf", rdrf, 1);
    read_clear();
    check("R11 or cleared", {rdrf, ovr}, 0); check("R11 data", data, 9'h011);
  endtask

  task automatic t_parity();
    pen = 1; podd = 0;
    send_frame(9'h003, 8, 1'b1, -1, 0); slots(1'b1, 4);
    check("R12 even ok", pe, 0); read_clear();
    send_frame(9'h007, 8, 1'b1, -1, 0); slots(1'b1, 4);
    check("R12 even bad", pe, 1); read_clear();
    podd = 1;
    send_frame(9'h000, 8, 1'b0, -1, 0); slots(1'b1, 4);
    check("R12 odd break pe", pe, 1); check("R12 odd break brk", brk, 1);
    read_clear();
    pen = 0; podd = 0;
  endtask

  task automatic t_active();
    send_bit(1'b0, 0); send_bit(1'b1, 0);
    check("R13 raf mid-frame", raf, 1);
    for (int i = 1; i < 8; i++) send_bit(1'b0, 0);
    send_bit(1'b1, 0); slots(1'b1, 8);
    check("R13 raf idle", raf, 0); check("R13 data", data, 9'h001);
    read_clear();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    slots(1'b1, 8);
    t_basic8();
    t_noise();
    t_nine();
    t_false_start();
    t_frame_err();
    t_break();
    t_break9();
    t_wait_high();
    t_overrun();
    t_parity();
    t_active();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule